// File: doc/BRIEF.md
# I2C Controller Register Bank

This block is the processor-facing side of an I2C master. It decodes eight 32-bit registers, chosen by a three-bit word index. Each index is the byte offset divided by four: control 0x00, status 0x04, length 0x08, target address 0x0C, data port 0x10, clock divider 0x14, edge delay 0x18 and stretch timeout 0x1C. Two byte FIFOs sit between software and the transfer engine. Software fills the transmit FIFO and empties the receive FIFO through the data port. The engine pops the transmit FIFO and pushes the receive FIFO through a small strobe handshake.

The status word has two kinds of bits. Some are live flags, computed each cycle from the FIFO fill levels and the engine's activity. Others are sticky event flags, which the engine sets with one-cycle pulses and software clears by writing one. One interrupt line combines three event classes, and each class has its own enable: done, transmit-wants-data and receive-needs-reading. The control fields and configuration registers are driven straight out to the engine. The start request reaches the engine as a one-cycle pulse.

Top module: `i2c_regbank`

## Requirements
- R1: After reset every register reads zero, except status, which reads 0x50 (TX may accept in bit 4, TX empty in bit 6). The interrupt output is low.
- R2: Control bits 0 (read), 8, 9, 10 (done, TX and RX interrupt enables) and 15 (enable) read back as written. Bits 4, 5 (clear) and 7 (start) always read 0. Writing bit 7 gives a one-cycle start pulse to the engine in the cycle after the write.
- R3: A control write with bit 4 or bit 5 set empties both FIFOs.
- R4: A write to the data port pushes bits 7:0 into the 16-deep TX FIFO. The engine sees the bytes in first-in, first-out order. A push to a full FIFO is dropped.
- R5: A read of the data port returns the oldest RX byte and removes it. A read of an empty RX FIFO returns 0 and changes nothing.
- R6: Status bit 4 is TX not full, bit 5 RX not empty, bit 6 TX empty and bit 7 RX full.
- R7: Status bit 2 is set while the engine is active, the read bit is 0 and the TX FIFO holds fewer than 4 bytes.
- R8: Status bit 3 is set while the engine is active, the read bit is 1 and the RX FIFO holds more than 12 bytes.
- R9: Status bits 1 (done), 8 (acknowledge error) and 9 (stretch timeout) are set by engine pulses. Writing 1 to a bit clears it and writing 0 leaves it set. Status bit 0 follows the engine's active signal.
- R10: The interrupt output is the OR of: done AND control bit 8, status bit 2 AND control bit 9, and status bit 3 AND control bit 10.
- R11: While the engine is active, the length register reads the byte count still to go: it is loaded at start and reduced by each byte-done pulse. When the engine is idle it reads the last value written.
- R12: The target address (7 bits), divider (16 bits), edge delay (32 bits) and stretch timeout (16 bits) read back as written and drive the matching engine outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWordAddr | input | 3 | Register word index |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (pops the RX FIFO at the data port) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the selected register |
| irqOut | output | 1 | Combined interrupt |
| engStart | output | 1 | One-cycle start request |
| engRead | output | 1 | Transfer direction (1 = read) |
| engEnable | output | 1 | Controller enable |
| engSlave | output | 7 | Target address |
| engLength | output | 16 | Programmed byte count |
| engDivider | output | 16 | Clock divider |
| engDelay | output | 32 | Edge delay setting |
| engStretch | output | 16 | Stretch timeout |
| engTxData | output | 8 | Oldest TX byte |
| engTxAvail | output | 1 | TX FIFO not empty |
| engRxRoom | output | 1 | RX FIFO not full |
| engActive | input | 1 | Transfer in progress |
| engDone | input | 1 | Transfer-finished pulse |
| engAckErr | input | 1 | Missing-acknowledge pulse |
| engTimeout | input | 1 | Stretch-timeout pulse |
| engByteDone | input | 1 | One byte transferred |
| engTxPop | input | 1 | Engine takes the oldest TX byte |
| engRxPush | input | 1 | Engine delivers an RX byte |
| engRxData | input | 8 | Received byte |

## Verification
The assertions assume that the engine's event inputs are single-cycle pulses, that reads and writes do not hit the bus in the same cycle, and that a start request is raised only by a control write. The stimulus keeps within these limits. Each register access takes exactly one strobed cycle followed by an idle cycle. Every engine event is one cycle wide and is driven away from the clock edge. The engine pops the TX FIFO only while it reports data available.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_STAT    = 3'd1,
    SEL_LEN     = 3'd2,
    SEL_SLAVE   = 3'd3,
    SEL_FIFO    = 3'd4,
    SEL_DIV     = 3'd5,
    SEL_DELAY   = 3'd6,
    SEL_STRETCH = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrStat;
    logic    wrLen;
    logic    wrSlave;
    logic    wrFifo;
    logic    rdFifo;
    logic    wrDiv;
    logic    wrDelay;
    logic    wrStretch;
    regSel_e rdSel;
  } busStrobe_t;

  // control bit positions
  localparam int CTL_READ    = 0;
  localparam int CTL_CLR_LO  = 4;
  localparam int CTL_CLR_HI  = 5;
  localparam int CTL_START   = 7;
  localparam int CTL_IE_DONE = 8;
  localparam int CTL_IE_TX   = 9;
  localparam int CTL_IE_RX   = 10;
  localparam int CTL_ENABLE  = 15;

  // status bit positions
  localparam int ST_ACTIVE   = 0;
  localparam int ST_DONE     = 1;
  localparam int ST_TX_WANT  = 2;
  localparam int ST_RX_NEED  = 3;
  localparam int ST_TX_ROOM  = 4;
  localparam int ST_RX_DATA  = 5;
  localparam int ST_TX_EMPTY = 6;
  localparam int ST_RX_FULL  = 7;
  localparam int ST_ACK_ERR  = 8;
  localparam int ST_TIMEOUT  = 9;

endpackage

// File: rtl/i2c_rb_fifo.sv
module i2c_rb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           flush,
  input  logic                           push,
  input  logic [WIDTH-1:0]               pushData,
  input  logic                           pop,
  output logic [WIDTH-1:0]               popData,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             isFull, isEmpty, doPush, doPop;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);
  assign doPush  = push && !isFull && !flush;
  assign doPop   = pop && !isEmpty && !flush;
  assign popData = isEmpty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: the fill level never passes the depth
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R5: popping an empty FIFO leaves it empty
  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pop && count == '0 && !push) |=> (count == '0));

endmodule

// File: rtl/i2c_rb_decode.sv
module i2c_rb_decode
  import i2c_regbank_pkg::*;
(
  input  logic [2:0]  busWordAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  output busStrobe_t  strobe
);
  regSel_e sel;

  always_comb begin
    sel           = regSel_e'(busWordAddr);
    strobe        = '0;
    strobe.rdSel  = sel;
    strobe.rdFifo = busRdEn && (sel == SEL_FIFO);
    case (sel)
      SEL_CTRL:    strobe.wrCtrl    = busWrEn;
      SEL_STAT:    strobe.wrStat    = busWrEn;
      SEL_LEN:     strobe.wrLen     = busWrEn;
      SEL_SLAVE:   strobe.wrSlave   = busWrEn;
      SEL_FIFO:    strobe.wrFifo    = busWrEn;
      SEL_DIV:     strobe.wrDiv     = busWrEn;
      SEL_DELAY:   strobe.wrDelay   = busWrEn;
      SEL_STRETCH: strobe.wrStretch = busWrEn;
      default:     strobe.wrCtrl    = 1'b0;
    endcase
  end

endmodule

// File: rtl/i2c_rb_datapath.sv
module i2c_rb_datapath
  import i2c_regbank_pkg::*;
#(
  parameter int FIFO_DEPTH   = 16,
  parameter int TX_LOW_MARK  = 4,
  parameter int RX_HIGH_MARK = 12,
  parameter int LEN_W        = 16,
  parameter int SLAVE_W      = 7,
  parameter int DIV_W        = 16,
  parameter int STRETCH_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic                 irqOut,
  output logic                 engStart,
  output logic                 engRead,
  output logic                 engEnable,
  output logic [SLAVE_W-1:0]   engSlave,
  output logic [LEN_W-1:0]     engLength,
  output logic [DIV_W-1:0]     engDivider,
  output logic [31:0]          engDelay,
  output logic [STRETCH_W-1:0] engStretch,
  output logic [7:0]           engTxData,
  output logic                 engTxAvail,
  output logic                 engRxRoom,
  input  logic                 engActive,
  input  logic                 engDone,
  input  logic                 engAckErr,
  input  logic                 engTimeout,
  input  logic                 engByteDone,
  input  logic                 engTxPop,
  input  logic                 engRxPush,
  input  logic [7:0]           engRxData
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] LOW_CNT  = CNT_W'(TX_LOW_MARK);
  localparam logic [CNT_W-1:0] HIGH_CNT = CNT_W'(RX_HIGH_MARK);

  logic                 ctrlRead, ieDone, ieTx, ieRx, ctrlEn;
  logic                 startPulse;
  logic [LEN_W-1:0]     lenReg, remaining;
  logic [SLAVE_W-1:0]   slaveReg;
  logic [DIV_W-1:0]     divReg;
  logic [31:0]          delayReg;
  logic [STRETCH_W-1:0] stretchReg;
  logic                 stickyDone, stickyAck, stickyTmo;

  logic                 flushReq, startReq;
  logic [CNT_W-1:0]     txCount, rxCount;
  logic [7:0]           rxHead;
  logic                 txWants, rxNeeds;
  logic [31:0]          ctrlView, statView;

  assign flushReq = strobe.wrCtrl && (busWrData[CTL_CLR_LO] || busWrData[CTL_CLR_HI]);
  assign startReq = strobe.wrCtrl && busWrData[CTL_START];

  i2c_rb_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flushReq),
    .push     (strobe.wrFifo),
    .pushData (busWrData[7:0]),
    .pop      (engTxPop),
    .popData  (engTxData),
    .count    (txCount)
  );

  i2c_rb_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flushReq),
    .push     (engRxPush),
    .pushData (engRxData),
    .pop      (strobe.rdFifo),
    .popData  (rxHead),
    .count    (rxCount)
  );

  // configuration and control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlRead   <= 1'b0;
      ieDone     <= 1'b0;
      ieTx       <= 1'b0;
      ieRx       <= 1'b0;
      ctrlEn     <= 1'b0;
      startPulse <= 1'b0;
      lenReg     <= '0;
      slaveReg   <= '0;
      divReg     <= '0;
      delayReg   <= '0;
      stretchReg <= '0;
    end else begin
      startPulse <= startReq;
      if (strobe.wrCtrl) begin
        ctrlRead <= busWrData[CTL_READ];
        ieDone   <= busWrData[CTL_IE_DONE];
        ieTx     <= busWrData[CTL_IE_TX];
        ieRx     <= busWrData[CTL_IE_RX];
        ctrlEn   <= busWrData[CTL_ENABLE];
      end
      if (strobe.wrLen)     lenReg     <= busWrData[LEN_W-1:0];
      if (strobe.wrSlave)   slaveReg   <= busWrData[SLAVE_W-1:0];
      if (strobe.wrDiv)     divReg     <= busWrData[DIV_W-1:0];
      if (strobe.wrDelay)   delayReg   <= busWrData;
      if (strobe.wrStretch) stretchReg <= busWrData[STRETCH_W-1:0];
    end
  end

  // remaining byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                remaining <= '0;
    else if (startReq)                        remaining <= lenReg;
    else if (engByteDone && remaining != '0)  remaining <= remaining - 1'b1;
  end

  // sticky events: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyDone <= 1'b0;
      stickyAck  <= 1'b0;
      stickyTmo  <= 1'b0;
    end else begin
      if (engDone)                                        stickyDone <= 1'b1;
      else if (strobe.wrStat && busWrData[ST_DONE])       stickyDone <= 1'b0;
      if (engAckErr)                                      stickyAck  <= 1'b1;
      else if (strobe.wrStat && busWrData[ST_ACK_ERR])    stickyAck  <= 1'b0;
      if (engTimeout)                                     stickyTmo  <= 1'b1;
      else if (strobe.wrStat && busWrData[ST_TIMEOUT])    stickyTmo  <= 1'b0;
    end
  end

  assign txWants = engActive && !ctrlRead && (txCount < LOW_CNT);
  assign rxNeeds = engActive && ctrlRead && (rxCount > HIGH_CNT);
  assign irqOut  = (stickyDone && ieDone) || (txWants && ieTx) || (rxNeeds && ieRx);

  always_comb begin
    ctrlView              = '0;
    ctrlView[CTL_READ]    = ctrlRead;
    ctrlView[CTL_IE_DONE] = ieDone;
    ctrlView[CTL_IE_TX]   = ieTx;
    ctrlView[CTL_IE_RX]   = ieRx;
    ctrlView[CTL_ENABLE]  = ctrlEn;

    statView              = '0;
    statView[ST_ACTIVE]   = engActive;
    statView[ST_DONE]     = stickyDone;
    statView[ST_TX_WANT]  = txWants;
    statView[ST_RX_NEED]  = rxNeeds;
    statView[ST_TX_ROOM]  = (txCount != FULL_CNT);
    statView[ST_RX_DATA]  = (rxCount != '0);
    statView[ST_TX_EMPTY] = (txCount == '0);
    statView[ST_RX_FULL]  = (rxCount == FULL_CNT);
    statView[ST_ACK_ERR]  = stickyAck;
    statView[ST_TIMEOUT]  = stickyTmo;

    case (strobe.rdSel)
      SEL_CTRL:    busRdData = ctrlView;
      SEL_STAT:    busRdData = statView;
      SEL_LEN:     busRdData = 32'(engActive ? remaining : lenReg);
      SEL_SLAVE:   busRdData = 32'(slaveReg);
      SEL_FIFO:    busRdData = 32'(rxHead);
      SEL_DIV:     busRdData = 32'(divReg);
      SEL_DELAY:   busRdData = delayReg;
      SEL_STRETCH: busRdData = 32'(stretchReg);
      default:     busRdData = '0;
    endcase
  end

  assign engStart   = startPulse;
  assign engRead    = ctrlRead;
  assign engEnable  = ctrlEn;
  assign engSlave   = slaveReg;
  assign engLength  = lenReg;
  assign engDivider = divReg;
  assign engDelay   = delayReg;
  assign engStretch = stretchReg;
  assign engTxAvail = (txCount != '0);
  assign engRxRoom  = (rxCount != FULL_CNT);

  // R2: a start pulse only follows a control write that asked for one
  assert_start_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> $past(strobe.wrCtrl && busWrData[CTL_START]));

  // R3: after a clear request both FIFOs are empty
  assert_flush_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (txCount == '0 && rxCount == '0));

  // R9: done stays set unless a one is written to its bit
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stickyDone && !(strobe.wrStat && busWrData[ST_DONE])) |=> stickyDone);

  // R10: the interrupt never rises without a source flag
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (stickyDone || txWants || rxNeeds));

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
  import i2c_regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busWordAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irqOut,
  output logic        engStart,
  output logic        engRead,
  output logic        engEnable,
  output logic [6:0]  engSlave,
  output logic [15:0] engLength,
  output logic [15:0] engDivider,
  output logic [31:0] engDelay,
  output logic [15:0] engStretch,
  output logic [7:0]  engTxData,
  output logic        engTxAvail,
  output logic        engRxRoom,
  input  logic        engActive,
  input  logic        engDone,
  input  logic        engAckErr,
  input  logic        engTimeout,
  input  logic        engByteDone,
  input  logic        engTxPop,
  input  logic        engRxPush,
  input  logic [7:0]  engRxData
);
  busStrobe_t strobe;

  i2c_rb_decode u_decode (
    .busWordAddr (busWordAddr),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .strobe      (strobe)
  );

  i2c_rb_datapath u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .irqOut      (irqOut),
    .engStart    (engStart),
    .engRead     (engRead),
    .engEnable   (engEnable),
    .engSlave    (engSlave),
    .engLength   (engLength),
    .engDivider  (engDivider),
    .engDelay    (engDelay),
    .engStretch  (engStretch),
    .engTxData   (engTxData),
    .engTxAvail  (engTxAvail),
    .engRxRoom   (engRxRoom),
    .engActive   (engActive),
    .engDone     (engDone),
    .engAckErr   (engAckErr),
    .engTimeout  (engTimeout),
    .engByteDone (engByteDone),
    .engTxPop    (engTxPop),
    .engRxPush   (engRxPush),
    .engRxData   (engRxData)
  );

endmodule

// File: tb/i2c_regbank_tb.sv
module i2c_regbank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busWordAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut, engStart, engRead, engEnable, engTxAvail, engRxRoom;
  logic [6:0]  engSlave;
  logic [15:0] engLength, engDivider, engStretch;
  logic [31:0] engDelay;
  logic [7:0]  engTxData;
  logic        engActive = 1'b0, engDone = 1'b0, engAckErr = 1'b0, engTimeout = 1'b0;
  logic        engByteDone = 1'b0, engTxPop = 1'b0, engRxPush = 1'b0;
  logic [7:0]  engRxData = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_LEN = 3'd2, A_SLAVE = 3'd3,
                         A_FIFO = 3'd4, A_DIV = 3'd5, A_DELAY = 3'd6, A_STRETCH = 3'd7;

  always #10 clk = ~clk;

  i2c_regbank u_dut (
    .clk(clk), .rstN(rstN), .busWordAddr(busWordAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut),
    .engStart(engStart), .engRead(engRead), .engEnable(engEnable), .engSlave(engSlave),
    .engLength(engLength), .engDivider(engDivider), .engDelay(engDelay),
    .engStretch(engStretch), .engTxData(engTxData), .engTxAvail(engTxAvail),
    .engRxRoom(engRxRoom), .engActive(engActive), .engDone(engDone),
    .engAckErr(engAckErr), .engTimeout(engTimeout), .engByteDone(engByteDone),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .engRxData(engRxData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWordAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busWordAddr = a; busRdEn = 1'b1;
    #2 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic evt(input bit d, input bit a, input bit t);
    @(negedge clk);
    engDone = d; engAckErr = a; engTimeout = t;
    @(negedge clk);
    engDone = 0; engAckErr = 0; engTimeout = 0;
  endtask

  task automatic rxPush(input logic [7:0] d);
    @(negedge clk);
    engRxPush = 1'b1; engRxData = d;
    @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic txPop();
    @(negedge clk);
    engTxPop = 1'b1;
    @(negedge clk);
    engTxPop = 1'b0;
  endtask

  task automatic byteDone();
    @(negedge clk);
    engByteDone = 1'b1;
    @(negedge clk);
    engByteDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    busRead(A_CTRL, v);  chk("R1 control after reset", v, 32'h0);
    busRead(A_STAT, v);  chk("R1 status after reset", v, 32'h50);
    busRead(A_LEN, v);   chk("R1 length after reset", v, 32'h0);
    busRead(A_DIV, v);   chk("R1 divider after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    busWrite(A_CTRL, 32'h0000_87B1);
    chk("R2 start pulse high", {31'b0, engStart}, 32'h1);
    @(negedge clk);
    chk("R2 start pulse single cycle", {31'b0, engStart}, 32'h0);
    busRead(A_CTRL, v);  chk("R2 control readback", v, 32'h0000_8701);
    chk("R2 engine read/enable", {30'b0, engRead, engEnable}, 32'h3);
    busWrite(A_CTRL, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    busWrite(A_SLAVE, 32'h0000_00D5);
    busWrite(A_DIV, 32'h0001_05DC);
    busWrite(A_DELAY, 32'h0030_0010);
    busWrite(A_STRETCH, 32'h0000_0040);
    busRead(A_SLAVE, v);   chk("R12 slave readback 7 bits", v, 32'h55);
    busRead(A_DIV, v);     chk("R12 divider readback", v, 32'h05DC);
    busRead(A_DELAY, v);   chk("R12 delay readback", v, 32'h0030_0010);
    busRead(A_STRETCH, v); chk("R12 stretch readback", v, 32'h40);
    chk("R12 engine slave", {25'b0, engSlave}, 32'h55);
    chk("R12 engine divider", {16'b0, engDivider}, 32'h05DC);
    chk("R12 engine delay", engDelay, 32'h0030_0010);
    chk("R12 engine stretch", {16'b0, engStretch}, 32'h40);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    for (int i = 0; i < 17; i++) busWrite(A_FIFO, 32'hFFFF_FF10 + i);
    busRead(A_STAT, v);
    chk("R6 TX full clears room bit", {31'b0, v[4]}, 32'h0);
    chk("R6 TX not empty", {31'b0, v[6]}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      chk("R4 TX order", {24'b0, engTxData}, 32'h10 + i);
      txPop();
    end
    chk("R4 17th push dropped", {31'b0, engTxAvail}, 32'h0);
    busRead(A_STAT, v);
    chk("R6 TX empty again", {31'b0, v[6]}, 32'h1);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    rxPush(8'hA1); rxPush(8'hB2); rxPush(8'hC3);
    busRead(A_STAT, v);  chk("R6 RX holds data", {31'b0, v[5]}, 32'h1);
    busRead(A_FIFO, v);  chk("R5 RX pop 1", v, 32'hA1);
    busRead(A_FIFO, v);  chk("R5 RX pop 2", v, 32'hB2);
    busRead(A_FIFO, v);  chk("R5 RX pop 3", v, 32'hC3);
    busRead(A_FIFO, v);  chk("R5 RX empty pop returns 0", v, 32'h0);
    busRead(A_STAT, v);  chk("R5 RX still empty", {31'b0, v[5]}, 32'h0);
    for (int i = 0; i < 16; i++) rxPush(8'(i));
    busRead(A_STAT, v);  chk("R6 RX full flag", {31'b0, v[7]}, 32'h1);
    chk("R6 RX no room", {31'b0, engRxRoom}, 32'h0);
    busRead(A_FIFO, v);  chk("R5 RX oldest after refill", v, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    busWrite(A_FIFO, 32'h11); busWrite(A_FIFO, 32'h22);
    busWrite(A_CTRL, 32'h20);
    busRead(A_STAT, v);  chk("R3 clear via bit 5", v & 32'hF0, 32'h50);
    busWrite(A_FIFO, 32'h33); rxPush(8'h44);
    busRead(A_STAT, v);  chk("R3 FIFOs loaded", v & 32'h60, 32'h20);
    busWrite(A_CTRL, 32'h10);
    busRead(A_STAT, v);  chk("R3 clear via bit 4", v & 32'hF0, 32'h50);
  endtask

  task automatic t_txWants();
    logic [31:0] v;
    @(negedge clk) engActive = 1'b1;
    busRead(A_STAT, v);  chk("R7 wants data when empty", {31'b0, v[2]}, 32'h1);
    for (int i = 0; i < 3; i++) busWrite(A_FIFO, 32'h1);
    busRead(A_STAT, v);  chk("R7 wants data at 3", {31'b0, v[2]}, 32'h1);
    busWrite(A_FIFO, 32'h1);
    busRead(A_STAT, v);  chk("R7 no want at 4", {31'b0, v[2]}, 32'h0);
    busWrite(A_CTRL, 32'h21);
    busRead(A_STAT, v);  chk("R7 no want in read mode", {31'b0, v[2]}, 32'h0);
    @(negedge clk) engActive = 1'b0;
    busWrite(A_CTRL, 32'h20);
  endtask

  task automatic t_rxNeeds();
    logic [31:0] v;
    busWrite(A_CTRL, 32'h1);
    @(negedge clk) engActive = 1'b1;
    for (int i = 0; i < 12; i++) rxPush(8'h5);
    busRead(A_STAT, v);  chk("R8 no need at 12", {31'b0, v[3]}, 32'h0);
    rxPush(8'h5);
    busRead(A_STAT, v);  chk("R8 need at 13", {31'b0, v[3]}, 32'h1);
    chk("R9 active bit follows engine", {31'b0, v[0]}, 32'h1);
    @(negedge clk) engActive = 1'b0;
    busRead(A_STAT, v);  chk("R8 no need when idle", {31'b0, v[3]}, 32'h0);
    chk("R9 active bit low when idle", {31'b0, v[0]}, 32'h0);
    busWrite(A_CTRL, 32'h20);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    evt(1, 1, 1);
    busRead(A_STAT, v);  chk("R9 events set", v & 32'h302, 32'h302);
    busWrite(A_STAT, 32'h0);
    busRead(A_STAT, v);  chk("R9 write 0 keeps events", v & 32'h302, 32'h302);
    busWrite(A_STAT, 32'h2);
    busRead(A_STAT, v);  chk("R9 done cleared only", v & 32'h302, 32'h300);
    busWrite(A_STAT, 32'h100);
    busRead(A_STAT, v);  chk("R9 ack error cleared", v & 32'h302, 32'h200);
    busWrite(A_STAT, 32'h200);
    busRead(A_STAT, v);  chk("R9 timeout cleared", v & 32'h302, 32'h0);
  endtask

  task automatic t_irq();
    busWrite(A_CTRL, 32'h100);
    chk("R10 no irq without done", {31'b0, irqOut}, 32'h0);
    evt(1, 0, 0);
    chk("R10 irq on done", {31'b0, irqOut}, 32'h1);
    busWrite(A_CTRL, 32'h0);
    chk("R10 done masked", {31'b0, irqOut}, 32'h0);
    busWrite(A_STAT, 32'h2);
    busWrite(A_CTRL, 32'h200);
    @(negedge clk) engActive = 1'b1;
    #1 chk("R10 irq on TX want", {31'b0, irqOut}, 32'h1);
    busWrite(A_CTRL, 32'h401);
    chk("R10 no irq, RX low", {31'b0, irqOut}, 32'h0);
    for (int i = 0; i < 13; i++) rxPush(8'h7);
    chk("R10 irq on RX need", {31'b0, irqOut}, 32'h1);
    busWrite(A_CTRL, 32'h21);
    chk("R10 irq gone after disable", {31'b0, irqOut}, 32'h0);
    @(negedge clk) engActive = 1'b0;
  endtask

  task automatic t_len();
    logic [31:0] v;
    busWrite(A_LEN, 32'h5);
    busWrite(A_CTRL, 32'h80);
    @(negedge clk) engActive = 1'b1;
    busRead(A_LEN, v);  chk("R11 remaining at start", v, 32'h5);
    byteDone(); byteDone();
    busRead(A_LEN, v);  chk("R11 remaining after 2", v, 32'h3);
    chk("R11 engine length unchanged", {16'b0, engLength}, 32'h5);
    @(negedge clk) engActive = 1'b0;
    busRead(A_LEN, v);  chk("R11 idle shows written", v, 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ctrl();
    t_regs();
    t_tx();
    t_rx();
    t_clear();
    t_txWants();
    t_rxNeeds();
    t_sticky();
    t_irq();
    t_len();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule